// File: doc/BRIEF.md
# Equal-Precision Reciprocal Frequency Counter

This block measures the frequency of a shaped digital input by counting, over one shared gate window, both the cycles of a known reference clock and the cycles of the input itself. A preset gate of programmable length is built in the reference domain. The real gate is that preset gate re-timed by a flip-flop clocked on the input's rising edges, so it always spans a whole number of input periods. Because of this, the plus-or-minus-one count error falls only on the reference count. Downstream logic or software forms the result fx = fref × Nx / Nref from the two raw counts.

A start pulse clears the previous result and launches a measurement. When the re-timed gate has closed and its synchronised copy has fallen, the block freezes both counts and raises a done flag. An overflow flag reports a count that wrapped. A timeout ends any measurement whose gate never closes and flags that no signal was present. All results are presented in the reference clock domain.

Top module: `freq_meter`

## Requirements
- R1: After reset, done, overflow and noSignal are low, and nsCount and nxCount are zero.
- R2: The real gate opens on the first input rising edge after the preset gate rises and closes on the first input rising edge after it falls. The preset gate is high for exactly gateLen reference cycles. nxCount equals the number of whole input periods spanned, so nxCount × Tsig lies within gateLen × Tref ± Tsig.
- R3: nsCount counts the reference cycles of the synchronised real gate: |nsCount × Tref − nxCount × Tsig| ≤ 2 × Tref when no count has wrapped.
- R4: nsCount does not change while the synchronised gate is low, except when it is cleared by an accepted start.
- R5: done rises one reference cycle after the synchronised real gate falls. It stays high, with both counts unchanged, until the next accepted start.
- R6: overflow is set when either counter wraps past its maximum value (2^CNT_W − 1) during a measurement. It stays set until the next accepted start.
- R7: If the gate has not closed within 2 × gateLen + REF_HZ reference cycles after start, the measurement is aborted and both noSignal and done are set. done appears between limit and limit+4 cycles after the start pulse.
- R8: A gateLen of 0 never raises the preset gate, so the measurement ends through the timeout with noSignal set.
- R9: A start pulse that arrives while a measurement is running is ignored. The result still reflects the original gateLen.
- R10: An accepted start clears nsCount, nxCount, done, overflow and noSignal by the next reference cycle.
- R11: Inputs faster than the reference clock are measured correctly, because the input count runs in the input's own clock domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Reference clock; all outputs are in this domain |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| sigIn | input | 1 | Shaped signal under measurement |
| start | input | 1 | One-cycle pulse that launches a measurement |
| gateLen | input | GATE_W | Preset gate length in reference cycles |
| nsCount | output | CNT_W | Reference cycles counted inside the real gate |
| nxCount | output | CNT_W | Input periods counted inside the real gate |
| done | output | 1 | Measurement finished; counts are valid |
| overflow | output | 1 | A counter wrapped during the measurement |
| noSignal | output | 1 | Measurement aborted by the timeout |

## Verification
The embedded properties check cycle-level invariants on every cycle:
- the reference count holds while the synchronised gate is low;
- done rises only with the gate closed and the preset gate low;
- noSignal never appears without done;
- overflow stays set once raised;
- a start pulse during a run leaves the preset down-count untouched.

Other behaviour can only be shown by the bench's scenarios:
- the whole-period alignment of the gate and the agreement between the two counts, at input periods both slower and faster than the reference;
- the timeout window for a missing input and for a zero gate length;
- overflow under a long gate.

// File: rtl/freq_meter_pkg.sv
package freq_meter_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2,
    ST_FIN   = 2'd3
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clearAll;    // accepted start: wipe counts and flags
    logic presetGate;  // registered preset gate, sampled by input domain
    logic capture;     // freeze input count into reference domain
  } gateCtrl_t;

endpackage

// File: rtl/freq_meter_sync.sv
module freq_meter_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/freq_meter_ctrl.sv
module freq_meter_ctrl
  import freq_meter_pkg::*;
#(
  parameter int GATE_W = 32,
  parameter int REF_HZ = 50_000_000
) (
  input  logic              refClk,
  input  logic              rstN,
  input  logic              start,
  input  logic [GATE_W-1:0] gateLen,
  input  logic              gateSync,
  output gateCtrl_t         strobes,
  output logic              done,
  output logic              noSignal
);

  localparam int REF_BITS = $clog2(REF_HZ + 1);
  localparam int TMO_W    = (((GATE_W + 1) > REF_BITS) ? (GATE_W + 1) : REF_BITS) + 1;

  phase_t            phase;
  logic [GATE_W-1:0] downCnt;
  logic [TMO_W-1:0]  tmoCnt;
  logic [TMO_W-1:0]  tmoLimit;
  logic [TMO_W-1:0]  limitNext;
  logic              presetReg;
  logic              seenOpen;
  logic              doneReg;
  logic              noSigReg;
  logic              busy;
  logic              accept;
  logic              closeSeen;
  logic              expired;

  assign busy      = (phase == ST_RUN) || (phase == ST_DRAIN);
  assign accept    = start && !busy;
  assign closeSeen = (phase == ST_DRAIN) && seenOpen && !gateSync;
  assign expired   = busy && (tmoCnt >= tmoLimit);
  assign limitNext = (TMO_W'(gateLen) << 1) + TMO_W'(REF_HZ);

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      phase     <= ST_IDLE;
      downCnt   <= '0;
      tmoCnt    <= '0;
      tmoLimit  <= '0;
      presetReg <= 1'b0;
      seenOpen  <= 1'b0;
      doneReg   <= 1'b0;
      noSigReg  <= 1'b0;
    end else if (accept) begin
      downCnt   <= gateLen;
      presetReg <= |gateLen;
      phase     <= (|gateLen) ? ST_RUN : ST_DRAIN;
      tmoCnt    <= '0;
      tmoLimit  <= limitNext;
      seenOpen  <= 1'b0;
      doneReg   <= 1'b0;
      noSigReg  <= 1'b0;
    end else if (busy) begin
      tmoCnt <= tmoCnt + TMO_W'(1);
      if (gateSync) seenOpen <= 1'b1;
      if (closeSeen) begin
        phase   <= ST_FIN;
        doneReg <= 1'b1;
      end else if (expired) begin
        phase     <= ST_FIN;
        doneReg   <= 1'b1;
        noSigReg  <= 1'b1;
        presetReg <= 1'b0;
      end else if (phase == ST_RUN) begin
        downCnt <= downCnt - GATE_W'(1);
        if (downCnt == GATE_W'(1)) begin
          presetReg <= 1'b0;
          phase     <= ST_DRAIN;
        end
      end
    end
  end

  assign strobes.clearAll   = accept;
  assign strobes.presetGate = presetReg;
  assign strobes.capture    = closeSeen;
  assign done               = doneReg;
  assign noSignal           = noSigReg;

  // R5: a normal completion only appears with the gate closed
  a_r5_done_after_close: assert property (@(posedge refClk) disable iff (!rstN)
    ($rose(done) && !noSignal) |-> (!gateSync && !presetReg));

  // R7: the no-signal flag never stands without done
  a_r7_nosig_has_done: assert property (@(posedge refClk) disable iff (!rstN)
    noSignal |-> done);

  // R9: a start during the preset window does not reload the down-counter
  a_r9_busy_start_ignored: assert property (@(posedge refClk) disable iff (!rstN)
    (phase == ST_RUN && start && !expired && downCnt > GATE_W'(1))
      |=> (phase == ST_RUN && downCnt == $past(downCnt) - GATE_W'(1)));

  // R10: an accepted start clears the flags on the next cycle
  a_r10_start_clears: assert property (@(posedge refClk) disable iff (!rstN)
    (start && !busy) |=> (!done && !noSignal));

endmodule

// File: rtl/freq_meter_datapath.sv
module freq_meter_datapath
  import freq_meter_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             refClk,
  input  logic             rstN,
  input  logic             sigIn,
  input  gateCtrl_t        strobes,
  output logic             gateSync,
  output logic [CNT_W-1:0] nsCount,
  output logic [CNT_W-1:0] nxCount,
  output logic             overflow
);

  logic             gateReal;
  logic [CNT_W-1:0] nxSig;
  logic             nxOvfSig;
  logic [CNT_W-1:0] nsCnt;
  logic             nsOvf;
  logic [CNT_W-1:0] nxHold;
  logic             ovfHold;

  // input domain: real gate flop and input-period counter
  always_ff @(posedge sigIn or negedge rstN) begin
    if (!rstN) gateReal <= 1'b0;
    else       gateReal <= strobes.presetGate;
  end

  always_ff @(posedge sigIn or negedge rstN) begin
    if (!rstN) begin
      nxSig    <= '0;
      nxOvfSig <= 1'b0;
    end else if (!gateReal && strobes.presetGate) begin
      nxSig    <= '0;            // opening edge
      nxOvfSig <= 1'b0;
    end else if (gateReal) begin
      nxSig <= nxSig + CNT_W'(1);  // includes the closing edge
      if (&nxSig) nxOvfSig <= 1'b1;
    end
  end

  freq_meter_sync #(.STAGES(SYNC_STAGES)) u_gateSync (
    .clk  (refClk),
    .rstN (rstN),
    .din  (gateReal),
    .dout (gateSync)
  );

  // reference domain: reference counter and quasi-static capture
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      nsCnt <= '0;
      nsOvf <= 1'b0;
    end else if (strobes.clearAll) begin
      nsCnt <= '0;
      nsOvf <= 1'b0;
    end else if (gateSync) begin
      nsCnt <= nsCnt + CNT_W'(1);
      if (&nsCnt) nsOvf <= 1'b1;
    end
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      nxHold  <= '0;
      ovfHold <= 1'b0;
    end else if (strobes.clearAll) begin
      nxHold  <= '0;
      ovfHold <= 1'b0;
    end else if (strobes.capture) begin
      nxHold  <= nxSig;
      ovfHold <= nsOvf | nxOvfSig;
    end
  end

  assign nsCount  = nsCnt;
  assign nxCount  = nxHold;
  assign overflow = ovfHold;

  // R4: the reference count only moves inside the synchronised gate
  a_r4_ns_hold: assert property (@(posedge refClk) disable iff (!rstN)
    (!gateSync && !strobes.clearAll) |=> $stable(nsCnt));

  // R6: overflow is sticky until a new start
  a_r6_ovf_sticky: assert property (@(posedge refClk) disable iff (!rstN)
    (ovfHold && !strobes.clearAll) |=> ovfHold);

endmodule

// File: rtl/freq_meter.sv
module freq_meter
  import freq_meter_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int GATE_W = 32,
  parameter int REF_HZ = 50_000_000
) (
  input  logic              refClk,
  input  logic              rstN,
  input  logic              sigIn,
  input  logic              start,
  input  logic [GATE_W-1:0] gateLen,
  output logic [CNT_W-1:0]  nsCount,
  output logic [CNT_W-1:0]  nxCount,
  output logic              done,
  output logic              overflow,
  output logic              noSignal
);

  gateCtrl_t strobes;
  logic      gateSync;

  freq_meter_ctrl #(.GATE_W(GATE_W), .REF_HZ(REF_HZ)) u_ctrl (
    .refClk   (refClk),
    .rstN     (rstN),
    .start    (start),
    .gateLen  (gateLen),
    .gateSync (gateSync),
    .strobes  (strobes),
    .done     (done),
    .noSignal (noSignal)
  );

  freq_meter_datapath #(.CNT_W(CNT_W), .SYNC_STAGES(2)) u_dp (
    .refClk   (refClk),
    .rstN     (rstN),
    .sigIn    (sigIn),
    .strobes  (strobes),
    .gateSync (gateSync),
    .nsCount  (nsCount),
    .nxCount  (nxCount),
    .overflow (overflow)
  );

endmodule

// File: tb/freq_meter_test.sv
`timescale 1ns/1ps
module freq_meter_test;

  localparam int  CNT_W  = 12;
  localparam int  GATE_W = 16;
  localparam int  REF_HZ = 1000;
  localparam real TREF   = 8.0;

  logic              refClk = 1'b0;
  logic              rstN   = 1'b0;
  logic              sigIn  = 1'b0;
  logic              start  = 1'b0;
  logic [GATE_W-1:0] gateLen = '0;
  logic [CNT_W-1:0]  nsCount;
  logic [CNT_W-1:0]  nxCount;
  logic              done;
  logic              overflow;
  logic              noSignal;

  freq_meter #(.CNT_W(CNT_W), .GATE_W(GATE_W), .REF_HZ(REF_HZ)) uut (
    .refClk(refClk), .rstN(rstN), .sigIn(sigIn), .start(start),
    .gateLen(gateLen), .nsCount(nsCount), .nxCount(nxCount),
    .done(done), .overflow(overflow), .noSignal(noSignal)
  );

  always #4 refClk = ~refClk;

  real sigHalf = 18.5;
  bit  sigRun  = 1'b0;
  initial begin
    #1.3;
    forever begin
      if (sigRun) begin
        #(sigHalf) sigIn = ~sigIn;
      end else begin
        sigIn = 1'b0;
        #1;
      end
    end
  end

  int cyc = 0;
  always @(posedge refClk) cyc++;

  int testsRun = 0;
  int testsFailed = 0;

  task automatic chk(bit ok, string req, string what, real act, real exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0.2f expected %0.2f", req, what, act, exp);
    end
  endtask

  typedef struct {
    int  len;
    real tsig;
    bit  expOvf;
    bit  expNoSig;
    int  startCyc;
  } item_t;

  item_t expQ[$];

  // monitor: pops one expected item per completed measurement
  bit prevDone = 1'b0;
  always @(negedge refClk) begin
    item_t it;
    real   span;
    real   lo;
    real   hi;
    int    limit;
    int    elapsed;
    if (rstN && done && !prevDone) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R9", "unexpected done", 1.0, 0.0);
      end else begin
        it = expQ.pop_front();
        chk(noSignal == it.expNoSig, it.expNoSig ? "R7" : "R2",
            "noSignal", real'(noSignal), real'(it.expNoSig));
        if (it.expNoSig) begin
          limit   = 2 * it.len + REF_HZ;
          elapsed = cyc - it.startCyc;
          chk(elapsed >= limit && elapsed <= limit + 4, it.len == 0 ? "R8" : "R7",
              "timeout cycles", real'(elapsed), real'(limit));
        end else begin
          chk(overflow == it.expOvf, "R6", "overflow", real'(overflow), real'(it.expOvf));
          span = real'(nxCount) * it.tsig;
          lo   = real'(it.len) * TREF - it.tsig;
          hi   = real'(it.len) * TREF + it.tsig;
          chk(span >= lo && span <= hi, (it.tsig < TREF) ? "R11" : "R2",
              "nx span ns", span, real'(it.len) * TREF);
          if (!it.expOvf) begin
            chk((real'(nsCount) * TREF - span) <= 2.0 * TREF &&
                (span - real'(nsCount) * TREF) <= 2.0 * TREF,
                (it.tsig < TREF) ? "R11" : "R3", "ns span ns",
                real'(nsCount) * TREF, span);
          end
        end
      end
    end
    prevDone = done;
  end

  // driver
  task automatic runMeas(int len, real tsig, bit run, bit expOvf, bit expNoSig, bit interrupt);
    item_t it;
    logic [CNT_W-1:0] nsSnap;
    logic [CNT_W-1:0] nxSnap;
    sigHalf = tsig / 2.0;
    sigRun  = run;
    repeat (20) @(negedge refClk);
    it.len = len; it.tsig = tsig; it.expOvf = expOvf; it.expNoSig = expNoSig;
    it.startCyc = cyc;
    expQ.push_back(it);
    gateLen = GATE_W'(len);
    start   = 1'b1;
    @(negedge refClk);
    start = 1'b0;
    // R10: flags and counts cleared one cycle after an accepted start
    chk(!done && !noSignal && !overflow, "R10", "flags after start",
        real'({done, noSignal, overflow}), 0.0);
    chk(nsCount == '0 && nxCount == '0, "R10", "counts after start",
        real'(nsCount) + real'(nxCount), 0.0);
    if (interrupt) begin
      repeat (50) @(negedge refClk);
      gateLen = GATE_W'(40);
      start   = 1'b1;
      @(negedge refClk);
      start = 1'b0;
      chk(!done, "R9", "done after busy start", real'(done), 0.0);
    end
    while (expQ.size() != 0) @(negedge refClk);
    nsSnap = nsCount;
    nxSnap = nxCount;
    repeat (5) @(negedge refClk);
    chk(done && nsCount == nsSnap && nxCount == nxSnap, "R5", "result held",
        real'(nsCount) + real'(nxCount), real'(nsSnap) + real'(nxSnap));
  endtask

  initial begin
    repeat (5) @(negedge refClk);
    // R1: reset state
    chk(!done && !overflow && !noSignal, "R1", "flags in reset",
        real'({done, overflow, noSignal}), 0.0);
    chk(nsCount == '0 && nxCount == '0, "R1", "counts in reset",
        real'(nsCount) + real'(nxCount), 0.0);
    rstN = 1'b1;
    repeat (3) @(negedge refClk);
    chk(!done && !overflow && !noSignal, "R1", "flags after reset",
        real'({done, overflow, noSignal}), 0.0);

    runMeas(200,  37.0,  1'b1, 1'b0, 1'b0, 1'b0);  // R2 R3
    runMeas(300,  100.0, 1'b1, 1'b0, 1'b0, 1'b0);  // R2 R3 slow input
    runMeas(400,  5.0,   1'b1, 1'b0, 1'b0, 1'b0);  // R11 input faster than reference
    runMeas(5000, 37.0,  1'b1, 1'b1, 1'b0, 1'b0);  // R6 reference count wraps
    runMeas(100,  37.0,  1'b0, 1'b0, 1'b1, 1'b0);  // R7 no input present
    runMeas(0,    37.0,  1'b1, 1'b0, 1'b1, 1'b0);  // R8 zero gate length
    runMeas(250,  73.0,  1'b1, 1'b0, 1'b0, 1'b0);  // R10 clear after no-signal
    runMeas(300,  37.0,  1'b1, 1'b0, 1'b0, 1'b1);  // R9 start while busy

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge refClk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule